// File: doc/BRIEF.md
# Fast-IR Receive Byte Escaper

This block sits between the fast-IR receive demodulator and the receive FIFO. It takes decoded bytes as a valid/ready stream, with a flag on the first byte of each frame and a flag on the last byte. It writes a byte stream in which every frame is wrapped in delimiter bytes of value 0x7E. The host can then split frames on 0x7E alone. The block does no CRC checking and no frame validation. The 32-bit CRC bytes at the end of a frame are handled like any other data byte.

When a frame starts, two 0x7E bytes go out ahead of its first data byte. When a frame ends, two 0x7E bytes follow its last data byte. Three data values would clash with the framing: 0x7D, 0x7E and 0x7F. Each of these leaves as a two-byte pair. The first byte of the pair is 0x7D and the second is the original value XOR 0x20. Frames may follow one another with no gap, and nothing is placed between them.

While the block sends a delimiter or the first byte of an escape pair, it holds its input stalled. Output backpressure therefore never loses a byte. Ordinary bytes in the middle of a frame pass at one byte per cycle.

Top module: `fir_rx_escaper`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high.
- R2: An input byte flagged with in_sof_i is preceded at the output by exactly two 0x7E bytes.
- R3: An input byte flagged with in_eof_i is followed at the output by exactly two 0x7E bytes.
- R4: A data byte 0x7D leaves as the pair 0x7D then 0x5D. While the 0x7D prefix is presented, in_ready_o is low.
- R5: A data byte 0x7E leaves as the pair 0x7D then 0x5E.
- R6: A data byte 0x7F leaves as the pair 0x7D then 0x5F. A raw 0x7F never appears at the output.
- R7: Every data byte other than 0x7D, 0x7E and 0x7F leaves as one byte, unchanged.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o does not change in the next cycle.
- R9: The output byte order equals the input order with delimiters and escapes applied. No byte is lost or duplicated under any pattern of out_ready_i.
- R10: Back-to-back frames each get their own delimiter pairs, with nothing inserted between one frame's closing pair and the next frame's opening pair.
- R11: A frame of one byte (both flags set) leaves as 0x7E 0x7E, the coded byte, 0x7E 0x7E.
- R12: With out_ready_i held high and input always valid, plain bytes in a frame and the delimiters of adjacent frames leave on consecutive cycles, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| in_data_i | input | 8 | Demodulated receive byte |
| in_sof_i | input | 1 | Byte is the first of a frame |
| in_eof_i | input | 1 | Byte is the last of a frame |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream FIFO can take a byte |
| out_data_o | output | 8 | Encoded byte stream |

## Verification
Two functions can fall in the same cycle. The last byte of a held item can be taken at the output (the second closing delimiter, or a plain data byte), and in that same cycle the next input byte can be accepted, possibly the first byte of a new frame. The bench provokes this by queuing frames back to back while out_ready_i follows a pseudo-random pattern. This places the handover cycle both under backpressure and without it. The collected output is compared byte for byte against a model of delimiters and escapes built in the bench, and a separate run with out_ready_i held high confirms that the handover costs no idle cycle.

// File: rtl/fir_esc_pkg.sv
package fir_esc_pkg;
  typedef enum logic [2:0] {
    ST_EMPTY,
    ST_BOF1,
    ST_BOF2,
    ST_ESC,
    ST_DATA,
    ST_EOF1,
    ST_EOF2
  } esc_state_e;
endpackage

// File: rtl/fir_esc_class.sv
module fir_esc_class #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ESC_BASE  = 'h7D,
  parameter int unsigned ESC_COUNT = 3,
  parameter int unsigned FLIP_MASK = 'h20
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              special_o,
  output logic [DATA_W-1:0] coded_o
);
  logic [ESC_COUNT-1:0] hit;

  for (genvar g = 0; g < ESC_COUNT; g++) begin : g_hit
    localparam logic [DATA_W-1:0] VAL = DATA_W'(ESC_BASE + g);
    assign hit[g] = (data_i == VAL);
  end

  assign special_o = |hit;
  assign coded_o   = special_o ? (data_i ^ DATA_W'(FLIP_MASK)) : data_i;
endmodule

// File: rtl/fir_esc_hold.sv
module fir_esc_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] coded_i,
  input  logic              special_i,
  input  logic              eof_i,
  output logic [DATA_W-1:0] coded_o,
  output logic              special_o,
  output logic              eof_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coded_o   <= '0;
      special_o <= 1'b0;
      eof_o     <= 1'b0;
    end else if (load_i) begin
      coded_o   <= coded_i;
      special_o <= special_i;
      eof_o     <= eof_i;
    end
  end
endmodule

// File: rtl/fir_esc_ctrl.sv
module fir_esc_ctrl
  import fir_esc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic       in_sof_i,
  input  logic       in_special_i,
  input  logic       hold_special_i,
  input  logic       hold_eof_i,
  input  logic       out_ready_i,
  output logic       in_ready_o,
  output logic       load_o,
  output logic       out_valid_o,
  output esc_state_e state_o
);
  esc_state_e state_q, state_d, first_st;
  logic fire, last_out;

  assign out_valid_o = (state_q != ST_EMPTY);
  assign fire        = out_valid_o && out_ready_i;
  // the held item is finished once this output is taken
  assign last_out    = ((state_q == ST_DATA) && !hold_eof_i) || (state_q == ST_EOF2);
  assign in_ready_o  = (state_q == ST_EMPTY) || (fire && last_out);
  assign load_o      = in_valid_i && in_ready_o;
  assign first_st    = in_sof_i ? ST_BOF1 : (in_special_i ? ST_ESC : ST_DATA);
  assign state_o     = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_EMPTY: if (load_o) state_d = first_st;
      ST_BOF1:  if (fire) state_d = ST_BOF2;
      ST_BOF2:  if (fire) state_d = hold_special_i ? ST_ESC : ST_DATA;
      ST_ESC:   if (fire) state_d = ST_DATA;
      ST_DATA:  if (fire) state_d = hold_eof_i ? ST_EOF1 : (load_o ? first_st : ST_EMPTY);
      ST_EOF1:  if (fire) state_d = ST_EOF2;
      ST_EOF2:  if (fire) state_d = load_o ? first_st : ST_EMPTY;
      default:  state_d = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_EMPTY;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/fir_rx_escaper.sv
module fir_rx_escaper
  import fir_esc_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DELIM     = 'h7E,
  parameter int unsigned ESC_BASE  = 'h7D,
  parameter int unsigned ESC_COUNT = 3,
  parameter int unsigned FLIP_MASK = 'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  localparam logic [DATA_W-1:0] DELIM_B = DATA_W'(DELIM);
  localparam logic [DATA_W-1:0] PREFIX_B = DATA_W'(ESC_BASE);

  logic              in_special, hold_special, hold_eof, load;
  logic [DATA_W-1:0] in_coded, hold_coded;
  esc_state_e        state;

  fir_esc_class #(
    .DATA_W(DATA_W), .ESC_BASE(ESC_BASE), .ESC_COUNT(ESC_COUNT), .FLIP_MASK(FLIP_MASK)
  ) u_class (
    .data_i(in_data_i), .special_o(in_special), .coded_o(in_coded)
  );

  fir_esc_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .load_i(load),
    .coded_i(in_coded), .special_i(in_special), .eof_i(in_eof_i),
    .coded_o(hold_coded), .special_o(hold_special), .eof_o(hold_eof)
  );

  fir_esc_ctrl u_ctrl (
    .clk_i, .rst_ni, .in_valid_i, .in_sof_i,
    .in_special_i(in_special), .hold_special_i(hold_special), .hold_eof_i(hold_eof),
    .out_ready_i, .in_ready_o, .load_o(load), .out_valid_o, .state_o(state)
  );

  always_comb begin
    unique case (state)
      ST_ESC:  out_data_o = PREFIX_B;
      ST_DATA: out_data_o = hold_coded;
      default: out_data_o = DELIM_B;
    endcase
  end
endmodule

// File: rtl/fir_rx_escaper_chk.sv
module fir_rx_escaper_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_sof_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o
);
  a_r1_ready_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  a_r2_bof_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_sof_i) |=> (out_valid_o && out_data_o == 8'h7E));

  a_r4_prefix_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_data_o == 8'h7D) |-> !in_ready_o);

  a_r5_prefix_followed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_data_o == 8'h7D) |=>
      (out_valid_o && (out_data_o == 8'h5D || out_data_o == 8'h5E || out_data_o == 8'h5F)));

  a_r6_no_raw_7f: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_data_o != 8'h7F));

  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

bind fir_rx_escaper fir_rx_escaper_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_sof_i(in_sof_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o)
);

// File: tb/fir_rx_escaper_test.sv
`timescale 1ns/1ps
module fir_rx_escaper_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid, in_ready, in_sof, in_eof, out_valid, out_ready;
  logic [7:0] in_data, out_data;

  always #10 clk = ~clk;  // 50 MHz

  fir_rx_escaper uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_sof_i(in_sof), .in_eof_i(in_eof),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  int checks = 0, failures = 0;
  logic [9:0]  tx_q[$];   // {sof, eof, data}
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic        acc = 1'b0;
  int          rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          cyc = 0;
  logic        timeout = 1'b0;
  logic        track = 1'b0;
  int          first_fire = -1, last_fire = -1, fires = 0;
  logic        prev_stall = 1'b0;
  logic [7:0]  prev_data = 8'h00;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  // queue one frame and its expected encoding
  task automatic send_frame(input logic [7:0] bytes[$]);
    for (int i = 0; i < bytes.size(); i++) begin
      logic s, e;
      s = (i == 0);
      e = (i == bytes.size() - 1);
      tx_q.push_back({s, e, bytes[i]});
      if (s) begin
        push_exp(8'h7E, "R2 bof");
        push_exp(8'h7E, "R2 bof");
      end
      if (bytes[i] == 8'h7D) begin
        push_exp(8'h7D, "R4 prefix"); push_exp(8'h5D, "R4 code");
      end else if (bytes[i] == 8'h7E) begin
        push_exp(8'h7D, "R5 prefix"); push_exp(8'h5E, "R5 code");
      end else if (bytes[i] == 8'h7F) begin
        push_exp(8'h7D, "R6 prefix"); push_exp(8'h5F, "R6 code");
      end else begin
        push_exp(bytes[i], "R7 plain");
      end
      if (e) begin
        push_exp(8'h7E, "R3 eof");
        push_exp(8'h7E, "R3 eof");
      end
    end
  endtask

  // driver: changes inputs on the falling edge only
  always @(negedge clk) begin
    if (acc && tx_q.size() > 0) void'(tx_q.pop_front());
    if (tx_q.size() > 0) begin
      in_valid = 1'b1;
      {in_sof, in_eof, in_data} = tx_q[0];
    end else begin
      in_valid = 1'b0;
      in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = cyc[0];
      default: out_ready = lfsr[0] | lfsr[3];
    endcase
  end

  // monitor: samples 2 ns before each rising edge
  always @(negedge clk) begin
    #8;
    cyc++;
    if (cyc > 150000) timeout = 1'b1;
    acc = rst_ni && in_valid && in_ready;
    if (rst_ni) begin
      if (prev_stall) chk(out_valid && out_data == prev_data, "R8 hold", int'(out_data), int'(prev_data));
      if (out_valid && out_data == 8'h7D) chk(!in_ready, "R4 stall", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 extra byte", int'(out_data), 0);
        end else begin
          chk(out_data == exp_q[0], tag_q[0], int'(out_data), int'(exp_q[0]));
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
        if (track) begin
          if (first_fire < 0) first_fire = cyc;
          last_fire = cyc;
          fires++;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic drain();
    wait ((tx_q.size() == 0 && exp_q.size() == 0) || timeout);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] f[$];
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #5;
    chk(!out_valid, "R1 valid", int'(out_valid), 0);
    chk(in_ready, "R1 ready", int'(in_ready), 1);

    // every byte value, 16-byte frames back to back, random backpressure (R9, R10)
    rdy_mode = 2;
    for (int fr = 0; fr < 16; fr++) begin
      f.delete();
      for (int k = 0; k < 16; k++) f.push_back(8'(fr * 16 + k));
      send_frame(f);
    end
    drain();

    // single-byte frames around the special values, alternating ready (R11)
    rdy_mode = 1;
    for (int v = 'h7B; v <= 'h81; v++) begin
      f.delete();
      f.push_back(8'(v));
      send_frame(f);
    end
    drain();

    // frames made only of special bytes, random ready
    rdy_mode = 2;
    for (int r = 0; r < 4; r++) begin
      f.delete();
      for (int k = 0; k < 6; k++) f.push_back(8'(8'h7D + (k + r) % 3));
      send_frame(f);
    end
    drain();

    // throughput: two plain frames, ready held high (R12, R10)
    rdy_mode = 0;
    track = 1'b1; first_fire = -1; last_fire = -1; fires = 0;
    for (int r = 0; r < 2; r++) begin
      f.delete();
      for (int k = 0; k < 8; k++) f.push_back(8'(8'h10 + k + r * 8));
      send_frame(f);
    end
    drain();
    track = 1'b0;
    chk(fires == 24, "R12 byte count", fires, 24);
    chk(last_fire - first_fire + 1 == fires, "R12 no idle", last_fire - first_fire + 1, fires);

    chk(exp_q.size() == 0, "R9 missing bytes", exp_q.size(), 0);
    chk(!timeout, "watchdog", int'(timeout), 0);
    @(negedge clk); #5;
    chk(!out_valid, "R10 nothing between", int'(out_valid), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule